// File: doc/BRIEF.md
# Minute-Resolution Watchdog Timer

This block is a system watchdog that counts down in whole minutes from an 8-bit timeout value loaded by software. A one-second strobe drives a prescaler. Every sixtieth strobe takes one step off the minute count. Software restarts the count by writing the timeout register. Either of two interrupt activity lines can also restart it: one from the serial ports and one from the keyboard and mouse. Each of these lines has its own enable.

When the count reaches zero, the block holds its active-low output low for exactly 250 millisecond strobes. At the same moment it can raise a one-cycle system-management request, a system-control request, or both, as the control register selects. A timeout of zero switches the watchdog off. Generating the one-second and one-millisecond strobes is left to the surrounding logic.

Top module: `minute_watchdog`

## Requirements
- R1: After reset the output wdoN is high, smiReq and sciReq are low, the timeout value is 0 (watchdog off) and all control enables are 0.
- R2: A write with wrSel=0 stores wrData as the timeout N and restarts the count, clearing the prescaler. With no later restart, expiry happens on the 60·N-th secTick after the write.
- R3: A timeout value of 0 disables the watchdog: no secTick sequence makes wdoN fall and no event request is raised.
- R4: When control bit 0 (wrSel=1 write) is 1, a rising edge on serIrq restarts the count. When the bit is 0, the edge is ignored.
- R5: When control bit 1 is 1, a rising edge on kbmIrq restarts the count. When the bit is 0, the edge is ignored.
- R6: An interrupt line held high restarts the count only once, on its rising edge.
- R7: wdoN goes low on the clock edge that samples the expiring secTick. It returns high on the edge that samples the 250th msTick after that, and not before.
- R8: After expiry the count stays at zero and no further pulse occurs until a restart.
- R9: smiReq (control bit 2) and sciReq (control bit 3) are one-cycle pulses in the cycle wdoN falls, each raised only when its bit is 1.
- R10: A restart in the same cycle as the expiring secTick wins: no expiry occurs, and the full timeout begins again.
- R11: A control write (wrSel=1) does not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle strobe once per second |
| msTick | input | 1 | One-cycle strobe once per millisecond |
| serIrq | input | 1 | Serial-port interrupt activity level |
| kbmIrq | input | 1 | Keyboard/mouse interrupt activity level |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0: timeout register, 1: control register |
| wrData | input | 8 | Write data (control: bit0 serial, bit1 kbm, bit2 smi, bit3 sci) |
| wdoN | output | 1 | Active-low expiry pulse |
| smiReq | output | 1 | System-management event request pulse |
| sciReq | output | 1 | System-control event request pulse |

## Verification
Every result of this block appears one clock edge after the strobe that causes it. wdoN falls at the edge that samples the expiring secTick, and smiReq and sciReq are high in the cycle after that same edge. wdoN rises at the edge that samples the 250th msTick. When the driver applies a strobe, it computes the index of the edge that will sample it and queues the expected wdoN transition stamped with that index. The monitor compares each observed wdoN edge and request pulse, at the falling clock edge, against the head of the queue. Any transition that nothing predicted is a failure, so ignored interrupts and disabled timeouts are caught as unexpected or missing edges.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef struct packed {
    logic loadTimeout;
    logic restart;
    logic secStep;
    logic pulseStart;
    logic pulseStep;
  } mwdStrobe_t;

  typedef struct packed {
    logic armed;
    logic lastStep;
    logic pulseLast;
  } mwdStatus_t;
endpackage

// File: rtl/mwd_datapath.sv
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRESCALE    = 60,
  parameter int PULSE_TICKS = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  mwdStrobe_t       stb,
  input  logic [CNT_W-1:0] wrData,
  output mwdStatus_t       status
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int PUL_W = $clog2(PULSE_TICKS);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [PUL_W-1:0] PUL_LAST = PUL_W'(PULSE_TICKS - 1);

  logic [CNT_W-1:0] timeoutReg;
  logic [CNT_W-1:0] count;
  logic [PRE_W-1:0] presc;
  logic [PUL_W-1:0] pulseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timeoutReg <= '0;
    else if (stb.loadTimeout) timeoutReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      presc <= '0;
    end else if (stb.restart) begin
      count <= stb.loadTimeout ? wrData : timeoutReg;
      presc <= '0;
    end else if (stb.secStep) begin
      if (presc == PRE_LAST) begin
        presc <= '0;
        count <= count - 1'b1;
      end else begin
        presc <= presc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (stb.pulseStart) pulseCnt <= '0;
    else if (stb.pulseStep) pulseCnt <= pulseCnt + 1'b1;
  end

  assign status.armed     = (count != '0);
  assign status.lastStep  = (count == CNT_W'(1)) && (presc == PRE_LAST);
  assign status.pulseLast = (pulseCnt == PUL_LAST);

  p_presc_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    presc < PRE_W'(PRESCALE));

  p_restart_clears_presc_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> presc == '0);

  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !stb.restart) |=> count == '0);

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.restart |=> (count == $past(count) || count == $past(count) - 1'b1));

  p_restart_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.restart && !stb.loadTimeout) |=> count == $past(timeoutReg));
endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       msTick,
  input  logic       serIrq,
  input  logic       kbmIrq,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic [3:0] cfgData,
  input  mwdStatus_t status,
  output mwdStrobe_t stb,
  output logic       wdoN,
  output logic       smiReq,
  output logic       sciReq
);
  logic serEn, kbmEn, smiEn, sciEn;
  logic serPrev, kbmPrev;
  logic pulseActive;
  logic serRise, kbmRise, expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serEn <= 1'b0;
      kbmEn <= 1'b0;
      smiEn <= 1'b0;
      sciEn <= 1'b0;
    end else if (wrEn && wrSel) begin
      serEn <= cfgData[0];
      kbmEn <= cfgData[1];
      smiEn <= cfgData[2];
      sciEn <= cfgData[3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serPrev <= 1'b0;
      kbmPrev <= 1'b0;
    end else begin
      serPrev <= serIrq;
      kbmPrev <= kbmIrq;
    end
  end

  always_comb begin
    serRise         = serIrq && !serPrev;
    kbmRise         = kbmIrq && !kbmPrev;
    stb.loadTimeout = wrEn && !wrSel;
    stb.restart     = stb.loadTimeout || (serEn && serRise) || (kbmEn && kbmRise);
    stb.secStep     = secTick && status.armed && !stb.restart;
    expire          = stb.secStep && status.lastStep;
    stb.pulseStart  = expire;
    stb.pulseStep   = pulseActive && msTick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseActive <= 1'b0;
      smiReq      <= 1'b0;
      sciReq      <= 1'b0;
    end else begin
      if (expire) pulseActive <= 1'b1;
      else if (stb.pulseStep && status.pulseLast) pulseActive <= 1'b0;
      smiReq <= expire && smiEn;
      sciReq <= expire && sciEn;
    end
  end

  assign wdoN = !pulseActive;

  p_start_on_expire_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> $past(expire));

  p_end_on_ms_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseActive) |-> $past(msTick));

  p_smi_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> ($past(smiEn) && pulseActive));

  p_sci_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    sciReq |-> ($past(sciEn) && pulseActive));
endmodule

// File: rtl/minute_watchdog.sv
module minute_watchdog
  import mwd_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRESCALE    = 60,
  parameter int PULSE_TICKS = 250
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             secTick,
  input  logic             msTick,
  input  logic             serIrq,
  input  logic             kbmIrq,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             wdoN,
  output logic             smiReq,
  output logic             sciReq
);
  mwdStrobe_t stb;
  mwdStatus_t status;

  mwd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .secTick (secTick),
    .msTick  (msTick),
    .serIrq  (serIrq),
    .kbmIrq  (kbmIrq),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .cfgData (wrData[3:0]),
    .status  (status),
    .stb     (stb),
    .wdoN    (wdoN),
    .smiReq  (smiReq),
    .sciReq  (sciReq)
  );

  mwd_datapath #(
    .CNT_W       (CNT_W),
    .PRESCALE    (PRESCALE),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .status (status)
  );
endmodule

// File: tb/minute_watchdog_tb.sv
`timescale 1ns/1ps
module minute_watchdog_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0, msTick = 1'b0, serIrq = 1'b0, kbmIrq = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic wdoN, smiReq, sciReq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit monOn = 1'b0;
  logic prevWdo = 1'b1;
  string curTag = "R1";

  int    qCyc[$];
  bit    qFall[$];
  bit    qSmi[$];
  bit    qSci[$];
  string qTag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  minute_watchdog u_dut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .msTick(msTick),
    .serIrq(serIrq), .kbmIrq(kbmIrq), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .wdoN(wdoN), .smiReq(smiReq), .sciReq(sciReq)
  );

  int    eCyc;
  bit    eFall, eSmi, eSci, fallNow;
  string eTag;

  always @(negedge clk) begin
    if (monOn) begin
      if (wdoN !== prevWdo) begin
        fallNow = (wdoN === 1'b0);
        checks++;
        if (qCyc.size() == 0) begin
          errors++;
          $display("FAIL %s: unexpected wdoN edge fall=%0d at cycle %0d, expected none",
                   curTag, fallNow, cyc);
        end else begin
          eCyc = qCyc.pop_front(); eFall = qFall.pop_front();
          eSmi = qSmi.pop_front(); eSci = qSci.pop_front(); eTag = qTag.pop_front();
          if (fallNow != eFall || cyc != eCyc ||
              (eFall && (smiReq !== eSmi || sciReq !== eSci))) begin
            errors++;
            $display("FAIL %s: edge fall=%0d cycle=%0d smi=%0d sci=%0d, expected fall=%0d cycle=%0d smi=%0d sci=%0d",
                     eTag, fallNow, cyc, smiReq, sciReq, eFall, eCyc, eSmi, eSci);
          end
        end
      end else if (smiReq || sciReq) begin
        checks++;
        errors++;
        $display("FAIL R9: request smi=%0d sci=%0d without wdoN fall at cycle %0d, expected 0 0",
                 smiReq, sciReq, cyc);
      end
      prevWdo = wdoN;
    end
  end

  task automatic pushExp(bit fall, bit s, bit c, string tag);
    qCyc.push_back(cyc + 1); qFall.push_back(fall);
    qSmi.push_back(s); qSci.push_back(c); qTag.push_back(tag);
  endtask

  task automatic secTicks(int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1'b1; @(negedge clk);
      secTick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic expireTick(string tag, bit s, bit c);
    pushExp(1'b1, s, c, tag);
    secTicks(1);
  endtask

  task automatic msRun(string tag);
    for (int i = 0; i < 249; i++) begin
      msTick = 1'b1; @(negedge clk);
      msTick = 1'b0; @(negedge clk);
    end
    pushExp(1'b0, 1'b0, 1'b0, tag);
    msTick = 1'b1; @(negedge clk);
    msTick = 1'b0; @(negedge clk);
  endtask

  task automatic writeReg(bit sel, logic [7:0] val);
    wrEn = 1'b1; wrSel = sel; wrData = val; @(negedge clk);
    wrEn = 1'b0; wrSel = 1'b0; wrData = '0; @(negedge clk);
  endtask

  task automatic irqPulse(bit kbm);
    if (kbm) kbmIrq = 1'b1; else serIrq = 1'b1;
    @(negedge clk);
    kbmIrq = 1'b0; serIrq = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkQuiet(string tag);
    checks++;
    if (wdoN !== 1'b1 || qCyc.size() != 0) begin
      errors++;
      $display("FAIL %s: wdoN=%0d pending=%0d, expected wdoN=1 pending=0", tag, wdoN, qCyc.size());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (wdoN !== 1'b1 || smiReq !== 1'b0 || sciReq !== 1'b0) begin
      errors++;
      $display("FAIL R1: wdoN=%0d smi=%0d sci=%0d, expected 1 0 0", wdoN, smiReq, sciReq);
    end
    prevWdo = wdoN;
    monOn = 1'b1;
    curTag = "R1"; secTicks(150); checkQuiet("R1");

    // R2 / R9: one minute, smi only
    curTag = "R2";
    writeReg(1'b1, 8'h04);
    writeReg(1'b0, 8'd1);
    secTicks(59); checkQuiet("R2");
    expireTick("R2", 1'b1, 1'b0);
    msRun("R7");

    // R8: stays expired
    curTag = "R8"; secTicks(150); checkQuiet("R8");

    // R3: zero disables
    curTag = "R3";
    writeReg(1'b0, 8'd2); secTicks(30);
    writeReg(1'b0, 8'd0); secTicks(200); checkQuiet("R3");

    // R2: two minutes, rewrite clears prescaler; R9 sci only
    curTag = "R2";
    writeReg(1'b1, 8'h08);
    writeReg(1'b0, 8'd2); secTicks(100);
    writeReg(1'b0, 8'd2); secTicks(119); checkQuiet("R2");
    expireTick("R2", 1'b0, 1'b1);
    msRun("R7");

    // R4: serial edge ignored when disabled
    curTag = "R4";
    writeReg(1'b1, 8'h00);
    writeReg(1'b0, 8'd1); secTicks(50);
    irqPulse(1'b0); secTicks(9);
    expireTick("R4", 1'b0, 1'b0);
    msRun("R7");

    // R4: serial edge restarts when enabled
    writeReg(1'b1, 8'h01);
    writeReg(1'b0, 8'd1); secTicks(50);
    irqPulse(1'b0); secTicks(59); checkQuiet("R4");
    expireTick("R4", 1'b0, 1'b0);
    msRun("R7");

    // R6: held level restarts once
    curTag = "R6";
    writeReg(1'b0, 8'd1); secTicks(10);
    serIrq = 1'b1; @(negedge clk);
    secTicks(59); checkQuiet("R6");
    expireTick("R6", 1'b0, 1'b0);
    serIrq = 1'b0;
    msRun("R7");

    // R5: kbm enabled, serial now ignored; R9 both events
    curTag = "R5";
    writeReg(1'b1, 8'h0E);
    writeReg(1'b0, 8'd1); secTicks(20);
    irqPulse(1'b0); secTicks(10);
    irqPulse(1'b1); secTicks(59); checkQuiet("R5");
    expireTick("R5", 1'b1, 1'b1);
    msRun("R7");

    // R10: restart coincident with expiring tick wins
    curTag = "R10";
    writeReg(1'b1, 8'h00);
    writeReg(1'b0, 8'd1); secTicks(59);
    secTick = 1'b1; wrEn = 1'b1; wrSel = 1'b0; wrData = 8'd1; @(negedge clk);
    secTick = 1'b0; wrEn = 1'b0; wrData = '0; @(negedge clk);
    secTicks(59); checkQuiet("R10");
    expireTick("R10", 1'b0, 1'b0);
    msRun("R7");

    // R11: control write does not restart
    curTag = "R11";
    writeReg(1'b0, 8'd1); secTicks(40);
    writeReg(1'b1, 8'h04); secTicks(19);
    expireTick("R11", 1'b1, 1'b0);
    msRun("R7");
    repeat (4) @(negedge clk);
    checkQuiet("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule